// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 32 by 32 pixel, two-colour pointer on top of a scanout pixel stream. The timing generator supplies each pixel with its screen column and line and its underlying RGB value; the block decides whether the pointer covers that pixel. It then passes the pixel through unchanged or replaces it with one of two overlay colours, which come from the palette block.

Software programs the pointer through a 32-bit register bus. One word holds the pointer's position. One bank of 32 words gives, for each pointer row, which pixels are opaque. A second bank of 32 words picks the colour of each opaque pixel. A single general-purpose control word can be stored and read back. The merged pixel leaves one clock after it arrives, together with a matching valid strobe. There is no state machine: the merge path is pure decode plus one pipeline register. The only state is the register bank.

Top module: `cursor_overlay`

## Requirements
- R1: A write to byte offset 0x8FC sets the pointer column from data bits 31:16 and the pointer line from bits 15:0. Pixels presented in later cycles use the new position.
- R2: A write to offset 0x900 + 4*r (r = 0..31) loads opacity row r. A write to offset 0x980 + 4*r loads colour row r.
- R3: Screen line Y uses row (Y - pointer line) for lines from the pointer line up to the pointer line + 31. Bit 31 of a row covers the pointer column, and bit 31-k covers pointer column + k.
- R4: A pixel whose opacity bit is 0 passes through. When the opacity bit is 1, a colour bit of 1 outputs `col_hi` and a colour bit of 0 outputs `col_lo`.
- R5: Pixels outside the 32 by 32 window pass through. The window test uses unsigned 16-bit coordinates with no wrap, so a pointer near line 0xFFFF does not cover line 0.
- R6: Pixels with column >= SCREEN_W pass through. When the pointer column is >= SCREEN_W, the pointer covers no pixel.
- R7: Reset sets both pointer coordinates to 0xF000 and clears both row banks and the control word. After reset `out_valid` and `rd_data` are 0.
- R8: A read of offset 0x818 returns the stored control word ORed with bit 25, on `rd_data` one cycle after `rd_en`. Writes to 0x818 store the full word.
- R9: A read of any other offset returns zero one cycle after `rd_en`. `rd_data` is zero in any cycle that does not follow a read.
- R10: `out_valid` equals `pix_valid` delayed by one cycle. `out_rgb` is the merge of the pixel and register state of that earlier cycle.
- R11: When a register write and a pixel arrive in the same cycle, the pixel is merged with the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| pix_valid | input | 1 | Incoming pixel valid |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel line |
| pix_rgb | input | PIX_W | Underlying pixel colour |
| col_lo | input | PIX_W | Overlay colour for colour bit 0 |
| col_hi | input | PIX_W | Overlay colour for colour bit 1 |
| out_valid | output | 1 | Merged pixel valid |
| out_rgb | output | PIX_W | Merged pixel |

## Verification
A register write and a pixel merge can happen in the same clock. A position or row update then races a pixel that the old or the new value would colour differently. The bench provokes this with directed cases: it drives a position write and a row write in the same cycle as a pixel the write would change. It expects the pre-write result, and then checks a follow-up pixel against the post-write state. Random traffic also interleaves writes and pixels back to back.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
    localparam int CUR_DIM = 32;
    localparam int ROW_W   = $clog2(CUR_DIM);
    localparam int COORD_W = 16;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int CTRL_FIXED_BIT = 25;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h818;
    localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
    localparam logic [ADDR_W-1:0] OFS_OPQ  = 12'h900;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h980;
    localparam logic [COORD_W-1:0] POS_PARK = 16'hF000;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } cur_pos_t;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } pix_sel_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_ovl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output cur_pos_t                      pos,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] opq_rows,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] clr_rows
);
    localparam int BANK_LSB = ROW_W + 2;
    localparam logic [DATA_W-1:0] FIXED_MASK = DATA_W'(1) << CTRL_FIXED_BIT;

    logic [DATA_W-1:0] ctrl_q;
    logic              opq_hit, clr_hit, pos_hit, ctrl_hit, rd_ctrl;
    logic [ROW_W-1:0]  row_sel;

    assign pos_hit  = wr_en && (wr_addr[ADDR_W-1:2] == OFS_POS[ADDR_W-1:2]);
    assign ctrl_hit = wr_en && (wr_addr[ADDR_W-1:2] == OFS_CTRL[ADDR_W-1:2]);
    assign opq_hit  = wr_en && (wr_addr[ADDR_W-1:BANK_LSB] == OFS_OPQ[ADDR_W-1:BANK_LSB]);
    assign clr_hit  = wr_en && (wr_addr[ADDR_W-1:BANK_LSB] == OFS_CLR[ADDR_W-1:BANK_LSB]);
    assign row_sel  = wr_addr[BANK_LSB-1:2];
    assign rd_ctrl  = rd_en && (rd_addr[ADDR_W-1:2] == OFS_CTRL[ADDR_W-1:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos.x  <= POS_PARK;
            pos.y  <= POS_PARK;
            ctrl_q <= '0;
        end else begin
            if (pos_hit) begin
                pos.x <= wr_data[DATA_W-1:COORD_W];
                pos.y <= wr_data[COORD_W-1:0];
            end
            if (ctrl_hit) ctrl_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opq_rows <= '0;
            clr_rows <= '0;
        end else begin
            for (int r = 0; r < CUR_DIM; r++) begin
                if (opq_hit && row_sel == ROW_W'(r)) opq_rows[r] <= wr_data;
                if (clr_hit && row_sel == ROW_W'(r)) clr_rows[r] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_ctrl) rd_data <= ctrl_q | FIXED_MASK;
        else              rd_data <= '0;
    end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
    import cursor_ovl_pkg::*;
#(
    parameter int SCREEN_W = 1024
) (
    input  logic [COORD_W-1:0]              pix_x,
    input  logic [COORD_W-1:0]              pix_y,
    input  cur_pos_t                        pos,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] opq_rows,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] clr_rows,
    output pix_sel_t                        sel
);
    localparam logic [COORD_W-1:0] SCR_LIM = COORD_W'(SCREEN_W);
    localparam logic [COORD_W-1:0] DIM_LIM = COORD_W'(CUR_DIM);

    logic [COORD_W-1:0] dx, dy;
    logic               in_x, in_y, on_screen, opaque, colour;
    logic [ROW_W-1:0]   row, col;

    always_comb begin
        dx        = pix_x - pos.x;
        dy        = pix_y - pos.y;
        in_x      = (pix_x >= pos.x) && (dx < DIM_LIM);
        in_y      = (pix_y >= pos.y) && (dy < DIM_LIM);
        on_screen = (pos.x < SCR_LIM) && (pix_x < SCR_LIM);
        row       = dy[ROW_W-1:0];
        col       = ~dx[ROW_W-1:0];
        opaque    = opq_rows[row][col];
        colour    = clr_rows[row][col];
        if (in_x && in_y && on_screen && opaque)
            sel = colour ? SEL_HI : SEL_LO;
        else
            sel = SEL_PASS;
    end
endmodule

// File: rtl/cursor_merge.sv
module cursor_merge
    import cursor_ovl_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_rgb,
    input  pix_sel_t         sel,
    input  logic [PIX_W-1:0] col_lo,
    input  logic [PIX_W-1:0] col_hi,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_rgb
);
    logic [PIX_W-1:0] merged;

    always_comb begin
        unique case (sel)
            SEL_LO:  merged = col_lo;
            SEL_HI:  merged = col_hi;
            default: merged = pix_rgb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_rgb   <= merged;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_ovl_pkg::*;
#(
    parameter int SCREEN_W = 1024,
    parameter int PIX_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [11:0]         wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [11:0]         rd_addr,
    output logic [31:0]         rd_data,
    input  logic                pix_valid,
    input  logic [15:0]         pix_x,
    input  logic [15:0]         pix_y,
    input  logic [PIX_W-1:0]    pix_rgb,
    input  logic [PIX_W-1:0]    col_lo,
    input  logic [PIX_W-1:0]    col_hi,
    output logic                out_valid,
    output logic [PIX_W-1:0]    out_rgb
);
    cur_pos_t                        pos;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] opq_rows;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] clr_rows;
    pix_sel_t                        sel;

    cursor_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pos      (pos),
        .opq_rows (opq_rows),
        .clr_rows (clr_rows)
    );

    cursor_hit #(.SCREEN_W(SCREEN_W)) u_hit (
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .pos      (pos),
        .opq_rows (opq_rows),
        .clr_rows (clr_rows),
        .sel      (sel)
    );

    cursor_merge #(.PIX_W(PIX_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_rgb   (pix_rgb),
        .sel       (sel),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int SCREEN_W = 1024,
    parameter int PIX_W    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [11:0]      wr_addr,
    input logic [31:0]      wr_data,
    input logic             rd_en,
    input logic [11:0]      rd_addr,
    input logic [31:0]      rd_data,
    input logic             pix_valid,
    input logic [15:0]      pix_x,
    input logic [15:0]      pix_y,
    input logic [PIX_W-1:0] pix_rgb,
    input logic [PIX_W-1:0] col_lo,
    input logic [PIX_W-1:0] col_hi,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_rgb
);
    localparam logic [15:0] SCR_LIM = 16'(SCREEN_W);

    // Shadow of the pointer position, rebuilt from bus writes alone.
    logic [15:0] sh_x, sh_y;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_x <= 16'hF000;
            sh_y <= 16'hF000;
        end else if (wr_en && wr_addr[11:2] == 10'h23F) begin
            sh_x <= wr_data[31:16];
            sh_y <= wr_data[15:0];
        end
    end

    p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    p_left_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x < sh_x) |=> out_rgb == $past(pix_rgb));
    p_above_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_y < sh_y) |=> out_rgb == $past(pix_rgb));
    p_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (pix_x >= SCR_LIM || sh_x >= SCR_LIM)) |=> out_rgb == $past(pix_rgb));
    p_legal_colour_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (out_rgb == $past(pix_rgb) || out_rgb == $past(col_lo)
                       || out_rgb == $past(col_hi)));
    p_ctrl_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[11:2] == 10'h206) |=> rd_data[25]);
    p_other_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr[11:2] == 10'h206) |=> rd_data == 32'h0);
endmodule

bind cursor_overlay cursor_overlay_chk #(.SCREEN_W(SCREEN_W), .PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb), .col_lo(col_lo), .col_hi(col_hi),
    .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
    localparam int SCR_W = 1024;
    localparam logic [23:0] C_LO = 24'h112233;
    localparam logic [23:0] C_HI = 24'hEEDDCC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pix_valid = 1'b0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;

    logic [15:0] cx, cy;
    logic [31:0] m_opq [32];
    logic [31:0] m_clr [32];
    logic [31:0] m_ctrl;

    always #4 clk = ~clk;

    cursor_overlay #(.SCREEN_W(SCR_W), .PIX_W(24)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb), .col_lo(C_LO), .col_hi(C_HI),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] f_exp(input logic [15:0] x, input logic [15:0] y, input logic [23:0] rgb);
        int dx, dy;
        dx = int'(x) - int'(cx);
        dy = int'(y) - int'(cy);
        if (int'(cx) >= SCR_W || int'(x) >= SCR_W) return rgb;
        if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return rgb;
        if (!m_opq[dy][31-dx]) return rgb;
        return m_clr[dy][31-dx] ? C_HI : C_LO;
    endfunction

    function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h8FC) begin cx = d[31:16]; cy = d[15:0]; end
        else if (a == 12'h818) m_ctrl = d;
        else if (a >= 12'h900 && a <= 12'h97C) m_opq[(a - 12'h900) >> 2] = d;
        else if (a >= 12'h980 && a <= 12'h9FC) m_clr[(a - 12'h980) >> 2] = d;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic px(input logic [15:0] x, input logic [15:0] y, input logic [23:0] rgb, input string req);
        logic [23:0] e;
        e = f_exp(x, y, rgb);
        @(negedge clk); pix_valid = 1'b1; pix_x = x; pix_y = y; pix_rgb = rgb;
        @(negedge clk); pix_valid = 1'b0;
        check(out_valid && out_rgb == e, req, {7'd0, out_valid, out_rgb}, {8'h01, e});
    endtask

    // R11: write and pixel share one cycle; pixel must see the old state
    task automatic wr_px(input logic [11:0] a, input logic [31:0] d,
                         input logic [15:0] x, input logic [15:0] y, input logic [23:0] rgb);
        logic [23:0] e;
        e = f_exp(x, y, rgb);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        pix_valid = 1'b1; pix_x = x; pix_y = y; pix_rgb = rgb;
        @(negedge clk); wr_en = 1'b0; pix_valid = 1'b0;
        check(out_rgb == e, "R11 same-cycle write", {8'd0, out_rgb}, {8'd0, e});
        model_wr(a, d);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        cx = 16'hF000; cy = 16'hF000; m_ctrl = '0;
        for (int i = 0; i < 32; i++) begin m_opq[i] = '0; m_clr[i] = '0; end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(rd_data == 32'd0, "R7 rd_data after reset", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7/R8: control word cleared, bit 25 forced on read
        rd(12'h818, 32'h0200_0000, "R7 R8 control after reset");
        wr(12'h818, 32'h00A5_0001);
        rd(12'h818, 32'h02A5_0001, "R8 control readback");
        // R9: other offsets read zero
        wr(12'h8FC, 32'h0064_0032);
        rd(12'h8FC, 32'h0, "R9 position read");
        rd(12'h900, 32'h0, "R9 opacity read");
        rd(12'h000, 32'h0, "R9 unmapped read");

        // R7: parked pointer covers nothing even with full opacity
        wr(12'h8FC, 32'hF000_F000);
        for (int r = 0; r < 32; r++) begin wr(12'h900 + 12'(r*4), 32'hFFFF_FFFF); wr(12'h980 + 12'(r*4), $urandom); end
        px(16'd0, 16'd0, 24'h010203, "R7 parked pointer");
        px(16'd100, 16'd100, 24'h040506, "R7 parked pointer");

        // R1 R2 R3 R4 directed
        wr(12'h8FC, 32'h0064_0032);
        wr(12'h900, 32'h8000_0001);
        wr(12'h980, 32'h8000_0000);
        px(16'd100, 16'd50, 24'hA0A0A0, "R3 R4 bit31 colour hi");
        px(16'd131, 16'd50, 24'hA0A0A0, "R3 R4 bit0 colour lo");
        px(16'd101, 16'd50, 24'hA0A0A0, "R4 transparent");
        wr(12'h97C, 32'h0000_0100);
        wr(12'h9FC, 32'h0000_0100);
        px(16'd123, 16'd81, 24'h555555, "R2 R3 last row");
        px(16'd123, 16'd82, 24'h555555, "R5 below window");
        px(16'd99, 16'd50, 24'h555555, "R5 left of window");
        px(16'd132, 16'd50, 24'h555555, "R5 right of window");

        // R10: valid follows by one cycle, bubble gives low
        @(negedge clk);
        check(out_valid == 1'b0, "R10 bubble", {31'd0, out_valid}, 32'd0);

        // R11: same-cycle writes
        wr_px(12'h8FC, 32'h00C8_0032, 16'd100, 16'd50, 24'h123456);
        px(16'd100, 16'd50, 24'h123456, "R1 R11 post-write position");
        px(16'd200, 16'd50, 24'h123456, "R1 new position");
        wr_px(12'h900, 32'h0, 16'd200, 16'd50, 24'h654321);
        px(16'd200, 16'd50, 24'h654321, "R11 post-write row");

        // R6: right edge clipping
        wr(12'h900, 32'hFFFF_FFFF);
        wr(12'h8FC, {16'(SCR_W - 8), 16'd10});
        px(16'(SCR_W - 1), 16'd10, 24'h777777, "R6 last column drawn");
        px(16'(SCR_W), 16'd10, 24'h777777, "R6 beyond width");
        wr(12'h8FC, {16'(SCR_W), 16'd10});
        px(16'(SCR_W + 2), 16'd10, 24'h777777, "R6 pointer off right");

        // R5: unsigned, no wrap at top
        wr(12'h8FC, 32'h00C8_FFF0);
        px(16'd200, 16'hFFF5, 24'h999999, "R5 high line drawn");
        px(16'd200, 16'd5, 24'h999999, "R5 no wrap");

        // random traffic
        for (int it = 0; it < 1500; it++) begin
            int k;
            k = int'($urandom % 8);
            if (k == 0) wr(12'h900 + 12'(($urandom % 32) * 4), $urandom);
            else if (k == 1) wr(12'h980 + 12'(($urandom % 32) * 4), $urandom);
            else if (k == 2) wr(12'h8FC, {16'($urandom % 1100), 16'($urandom % 800)});
            else if (k == 3) wr_px(12'h8FC, {16'($urandom % 1100), 16'($urandom % 800)},
                                   cx + 16'($urandom % 48) - 16'd8, cy + 16'($urandom % 48) - 16'd8, 24'($urandom));
            else px(cx + 16'($urandom % 48) - 16'd8, cy + 16'($urandom % 48) - 16'd8, 24'($urandom),
                    "R3 R4 R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule